// File: doc/BRIEF.md
# UART Transmitter with Drain-Controlled Pin Release

This block is the transmit half of a serial port. A bus-side agent reads and writes an 8-bit control register at any time. It also loads bytes into a single-entry holding buffer. The block moves each byte into a shift register and sends it on a TX line as an asynchronous frame. The TX line has an output-enable next to it, so the pad can float when the transmitter has let go of it. Bit timing comes from an external baud tick. One bit lasts a fixed number of ticks.

Besides data, the transmitter can send two special characters. An idle character is a full frame time of mark level. It is queued by switching the transmit enable off and then back on while a character is still going out. A break character is a full frame time of space level. It is queued by a rising edge on the send-break control bit. When software clears the enable, the pin stays driven until every character already accepted has left the shifter. Only then does the output-enable drop. Two flags report progress: holding buffer empty, and all traffic finished. They are combined with per-flag enables into a single interrupt request.

Top module: `uart_txc`

## Requirements
- R1: After reset the control register reads 0x00, tx_oe is 0, tx_out is 1, buf_empty is 1, tx_done is 1 and irq is 0.
- R2: A write to the control register is accepted in any cycle, including while a character is being sent. All 8 bits read back on reg_rdata from the next cycle onward.
- R3: A data character is a start bit at 0, then 8 data bits least significant first, then a stop bit at 1. Each bit lasts 16 baud ticks. With no character in progress the line is 1.
- R4: buf_empty goes to 0 on a data write. It returns to 1 only when the buffered byte is moved into the shifter, so a byte written during a frame keeps buf_empty at 0 until that frame ends.
- R5: tx_done goes to 0 on a data write or when an idle or break character is queued. It goes to 1 once the shifter is empty and no data, idle or break work is pending.
- R6: irq is 1 exactly when (buf_empty and control bit 7) or (tx_done and control bit 6). Control bits 5, 4, 2 and 1 are stored and read back but have no effect on irq or on the line.
- R7: Control bit 3 is the transmit enable. One cycle after it becomes 1, tx_oe is 1. If it is 0 and no work is in flight, tx_oe is 0.
- R8: When the transmit enable is cleared with work in flight, tx_oe stays 1 (and the line is only ever 0 while tx_oe is 1). Pending characters are still sent. tx_oe drops within a few cycles of the last one finishing.
- R9: Writing the transmit enable from 0 to 1 while the shifter is busy queues one idle character: 10 bit-times of 1 after the current character and before any buffered byte.
- R10: A write that takes control bit 0 from 0 to 1 while also leaving bit 3 at 1 queues a break: 10 bit-times of 0. The service order is: current character, then break, then idle, then buffered data.
- R11: While the transmit enable is 0 and tx_oe is 0, a written byte stays buffered and is not sent. It goes out after the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register contents |
| dat_wr | input | 1 | Transmit buffer write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| baud_tick | input | 1 | One-cycle baud tick, 16 per bit |
| tx_out | output | 1 | Serial line level |
| tx_oe | output | 1 | Output-enable for the serial pad |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | All transmit work finished flag |
| irq | output | 1 | Interrupt request |

## Verification
A line monitor decodes every character from bit centres and also measures the mark time before each character. This lets it tell back-to-back frames apart from frames separated by a queued idle character. The byte values are chosen to expose bit-order and frame errors: 0x55, 0xC3, 0x0F, 0xF0, 0x81, 0x3C, 0x99, 0x42 and 0x7E. A break is recognised as a frame with a space-level stop position. Its order relative to a queued idle and a buffered byte shows the service priority. Further sequences clear the enable mid-traffic to check pin hold and release, hold a byte while the transmitter is disabled, and step the interrupt enables against both flags.

// File: rtl/uart_txc_pkg.sv
package uart_txc_pkg;
  typedef enum logic [1:0] {
    JOB_DATA  = 2'd0,
    JOB_IDLE  = 2'd1,
    JOB_BREAK = 2'd2
  } job_e;

  localparam int CTL_W      = 8;
  localparam int BIT_BUFIE  = 7;
  localparam int BIT_DONEIE = 6;
  localparam int BIT_TXEN   = 3;
  localparam int BIT_BRK    = 0;
endpackage

// File: rtl/uart_txc_ctl.sv
module uart_txc_ctl
  import uart_txc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             sh_busy,
  output logic [CTL_W-1:0] ctl,
  output logic             idle_req,
  output logic             brk_req
);
  logic [CTL_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) ctl_d = wdata;
  end

  // enable re-asserted while a character is leaving -> one idle char
  assign idle_req = wr & wdata[BIT_TXEN] & ~ctl_q[BIT_TXEN] & sh_busy;
  // break bit rising with the transmitter left enabled -> one break char
  assign brk_req  = wr & wdata[BIT_BRK] & ~ctl_q[BIT_BRK] & wdata[BIT_TXEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/uart_txc_sched.sv
module uart_txc_sched
  import uart_txc_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 te,
  input  logic                 dat_wr,
  input  logic [DATA_BITS-1:0] dat_wdata,
  input  logic                 idle_req,
  input  logic                 brk_req,
  input  logic                 sh_busy,
  output logic                 launch,
  output job_e                 job,
  output logic [DATA_BITS-1:0] job_data,
  output logic                 buf_empty,
  output logic                 tx_done,
  output logic                 oe
);
  logic [DATA_BITS-1:0] buf_q;
  logic full_q, full_d;
  logic pidle_q, pidle_d;
  logic pbrk_q, pbrk_d;
  logic oe_q, oe_d;
  logic done_q, done_d;
  logic can_go, work_left;

  assign can_go    = (te | oe_q) & ~sh_busy;
  assign work_left = sh_busy | full_q | pidle_q | pbrk_q;

  always_comb begin
    job = JOB_DATA;
    if (pbrk_q)       job = JOB_BREAK;
    else if (pidle_q) job = JOB_IDLE;
    launch = can_go & (pbrk_q | pidle_q | full_q);
  end

  always_comb begin
    pbrk_d  = brk_req  | (pbrk_q  & ~(launch & (job == JOB_BREAK)));
    pidle_d = idle_req | (pidle_q & ~(launch & (job == JOB_IDLE)));
    full_d  = dat_wr   | (full_q  & ~(launch & (job == JOB_DATA)));
    done_d  = ~(dat_wr | idle_req | brk_req) & ~work_left & ~launch;
    oe_d    = te | (oe_q & work_left);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      pidle_q <= 1'b0;
      pbrk_q  <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b1;
    end else begin
      full_q  <= full_d;
      pidle_q <= pidle_d;
      pbrk_q  <= pbrk_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (dat_wr) buf_q <= dat_wdata;
  end

  assign job_data  = buf_q;
  assign buf_empty = ~full_q;
  assign tx_done   = done_q;
  assign oe        = oe_q;
endmodule

// File: rtl/uart_txc_shift.sv
module uart_txc_shift
  import uart_txc_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start,
  input  job_e                 job,
  input  logic [DATA_BITS-1:0] data,
  output logic                 busy,
  output logic                 line
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [TW-1:0] TICK_LAST = TW'(OVERSAMPLE - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_BITS - 1);

  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d, frm_load;
  logic [TW-1:0]         tcnt_q, tcnt_d;
  logic [BW-1:0]         bcnt_q, bcnt_d;
  logic                  bit_end;

  always_comb begin
    case (job)
      JOB_IDLE:  frm_load = '1;
      JOB_BREAK: frm_load = '0;
      default:   frm_load = {1'b1, data, 1'b0};
    endcase
  end

  assign bit_end = busy_q & tick & (tcnt_q == TICK_LAST);

  always_comb begin
    busy_d = busy_q;
    frm_d  = frm_q;
    tcnt_d = tcnt_q;
    bcnt_d = bcnt_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      frm_d  = frm_load;
      tcnt_d = '0;
      bcnt_d = '0;
    end else if (busy_q && tick) begin
      tcnt_d = tcnt_q + 1'b1;
      if (bit_end) begin
        tcnt_d = '0;
        if (bcnt_q == BIT_LAST) begin
          busy_d = 1'b0;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
          frm_d  = {1'b1, frm_q[FRAME_BITS-1:1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      frm_q  <= '1;
      tcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      frm_q  <= frm_d;
      tcnt_q <= tcnt_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? frm_q[0] : 1'b1;
endmodule

// File: rtl/uart_txc.sv
module uart_txc
  import uart_txc_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [CTL_W-1:0]     reg_wdata,
  output logic [CTL_W-1:0]     reg_rdata,
  input  logic                 dat_wr,
  input  logic [DATA_BITS-1:0] dat_wdata,
  input  logic                 baud_tick,
  output logic                 tx_out,
  output logic                 tx_oe,
  output logic                 buf_empty,
  output logic                 tx_done,
  output logic                 irq
);
  logic rst_meta, rst_sync;
  logic [CTL_W-1:0] ctl;
  logic idle_req, brk_req, sh_busy, launch;
  job_e job;
  logic [DATA_BITS-1:0] job_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync, rst_meta} <= 2'b00;
    else        {rst_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  uart_txc_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr       (reg_wr),
    .wdata    (reg_wdata),
    .sh_busy  (sh_busy),
    .ctl      (ctl),
    .idle_req (idle_req),
    .brk_req  (brk_req)
  );

  uart_txc_sched #(.DATA_BITS(DATA_BITS)) u_sched (
    .clk       (clk),
    .rst_n     (rst_sync),
    .te        (ctl[BIT_TXEN]),
    .dat_wr    (dat_wr),
    .dat_wdata (dat_wdata),
    .idle_req  (idle_req),
    .brk_req   (brk_req),
    .sh_busy   (sh_busy),
    .launch    (launch),
    .job       (job),
    .job_data  (job_data),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .oe        (tx_oe)
  );

  uart_txc_shift #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk   (clk),
    .rst_n (rst_sync),
    .tick  (baud_tick),
    .start (launch),
    .job   (job),
    .data  (job_data),
    .busy  (sh_busy),
    .line  (tx_out)
  );

  assign reg_rdata = ctl;
  assign irq = (buf_empty & ctl[BIT_BUFIE]) | (tx_done & ctl[BIT_DONEIE]);
endmodule

// File: rtl/uart_txc_chk.sv
module uart_txc_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_ok,
  input logic                 reg_wr,
  input logic [7:0]           reg_wdata,
  input logic [7:0]           reg_rdata,
  input logic                 dat_wr,
  input logic                 tx_out,
  input logic                 tx_oe,
  input logic                 buf_empty,
  input logic                 tx_done,
  input logic                 irq
);
  AST_CTL_READBACK: assert property (@(posedge clk) disable iff (!rst_ok)
    reg_wr |=> (reg_rdata == $past(reg_wdata))); // R2

  AST_BUF_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    dat_wr |=> !buf_empty); // R4

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok)
    dat_wr |=> !tx_done); // R5

  AST_DONE_MARK: assert property (@(posedge clk) disable iff (!rst_ok)
    tx_done |-> tx_out); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_rdata[7:6] == 2'b00) |-> !irq); // R6

  AST_SPACE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_ok)
    !tx_out |-> tx_oe); // R8
endmodule

bind uart_txc uart_txc_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .dat_wr    (dat_wr),
  .tx_out    (tx_out),
  .tx_oe     (tx_oe),
  .buf_empty (buf_empty),
  .tx_done   (tx_done),
  .irq       (irq)
);

// File: tb/uart_txc_bench.sv
module uart_txc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every 2 clocks
  localparam logic [1:0] K_DATA = 2'd0, K_BRK = 2'd1, K_BAD = 2'd2;
  localparam logic [1:0] G_ANY = 2'd0, G_SHORT = 2'd1, G_LONG = 2'd2, G_MID = 2'd3;

  logic clk, rst_n;
  logic reg_wr, dat_wr, baud_tick;
  logic [7:0] reg_wdata, reg_rdata, dat_wdata;
  logic tx_out, tx_oe, buf_empty, tx_done, irq;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_q[$];
  string req_q[$];

  uart_txc u_uart_txc (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .baud_tick(baud_tick), .tx_out(tx_out), .tx_oe(tx_oe),
    .buf_empty(buf_empty), .tx_done(tx_done), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) baud_tick <= 1'b0;
    else        baud_tick <= ~baud_tick;
  end

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic expect_char(input logic [1:0] kind, input logic [1:0] gap,
                             input logic [7:0] d, input string req);
    exp_q.push_back({kind, gap, d});
    req_q.push_back(req);
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk);
    dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 6000 && exp_q.size() != 0; n++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk_eq("R3", "expected characters left unsent", exp_q.size(), 0);
  endtask

  // monitor: decodes characters at bit centres and classifies the mark gap before each
  initial begin
    int gap;
    logic [9:0] s;
    logic oe_bad;
    logic [1:0] kind, gc;
    logic [11:0] e;
    string rq;
    wait (rst_n === 1'b1);
    forever begin
      gap = 0;
      @(negedge clk);
      while (tx_out !== 1'b1) @(negedge clk);
      while (tx_out === 1'b1) begin @(negedge clk); gap++; end
      oe_bad = 1'b0;
      repeat (BIT_CLKS/2) @(negedge clk);
      for (int i = 0; i < 10; i++) begin
        s[i] = tx_out;
        if (tx_oe !== 1'b1) oe_bad = 1'b1;
        if (i < 9) repeat (BIT_CLKS) @(negedge clk);
      end
      if (s == 10'b0)                    kind = K_BRK;
      else if (!s[0] && s[9])            kind = K_DATA;
      else                               kind = K_BAD;
      if (gap < 40)        gc = G_SHORT;
      else if (gap >= 300) gc = G_LONG;
      else                 gc = G_MID;
      chk_eq("R8", "pad not driven during character", oe_bad, 1'b0);
      if (exp_q.size() == 0) begin
        chk_eq("R3", "unexpected character", {kind, gc, s[8:1]}, 12'hfff);
      end else begin
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        if (e[9:8] == G_ANY) e[9:8] = gc;
        chk_eq(rq, "character kind/gap/data",
               {kind, gc, (kind == K_BRK) ? 8'h00 : s[8:1]}, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; dat_wr = 1'b0;
    reg_wdata = '0; dat_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_eq("R1", "ctl after reset", reg_rdata, 8'h00);
    chk_eq("R1", "tx_oe after reset", tx_oe, 1'b0);
    chk_eq("R1", "tx_out after reset", tx_out, 1'b1);
    chk_eq("R1", "buf_empty after reset", buf_empty, 1'b1);
    chk_eq("R1", "tx_done after reset", tx_done, 1'b1);
    chk_eq("R1", "irq after reset", irq, 1'b0);

    // R2 / R6 / R7 register and interrupt gating, no transmitter
    wr_ctl(8'hA5);
    chk_eq("R2", "readback A5", reg_rdata, 8'hA5);
    chk_eq("R6", "irq from buf_empty enable", irq, 1'b1);
    @(negedge clk);
    chk_eq("R7", "tx_oe with enable 0", tx_oe, 1'b0);
    wr_ctl(8'h5A);
    chk_eq("R2", "readback 5A", reg_rdata, 8'h5A);
    chk_eq("R6", "irq from done enable", irq, 1'b1);
    @(negedge clk);
    chk_eq("R7", "tx_oe one cycle after enable", tx_oe, 1'b1);
    wr_ctl(8'h36);
    @(negedge clk);
    chk_eq("R2", "readback 36", reg_rdata, 8'h36);
    chk_eq("R6", "irq with only unrelated bits", irq, 1'b0);
    chk_eq("R7", "tx_oe released when idle", tx_oe, 1'b0);

    // R3 / R4 / R5 / R6 plain data traffic
    wr_ctl(8'h88);
    chk_eq("R6", "irq with empty buffer", irq, 1'b1);
    expect_char(K_DATA, G_ANY, 8'h55, "R3");
    wr_dat(8'h55);
    chk_eq("R4", "buf_empty after write", buf_empty, 1'b0);
    chk_eq("R5", "tx_done after write", tx_done, 1'b0);
    chk_eq("R6", "irq with full buffer", irq, 1'b0);
    expect_char(K_DATA, G_SHORT, 8'hC3, "R3");
    wr_dat(8'hC3);
    repeat (100) @(negedge clk);
    chk_eq("R4", "buf_empty held during frame", buf_empty, 1'b0);
    wr_ctl(8'hC8);
    chk_eq("R2", "readback during frame", reg_rdata, 8'hC8);
    drain();
    chk_eq("R4", "buf_empty after drain", buf_empty, 1'b1);
    chk_eq("R5", "tx_done after drain", tx_done, 1'b1);
    chk_eq("R6", "irq after drain", irq, 1'b1);

    // R9 queued idle character
    wr_ctl(8'h08);
    expect_char(K_DATA, G_ANY, 8'h0F, "R9");
    wr_dat(8'h0F);
    expect_char(K_DATA, G_LONG, 8'hF0, "R9");
    wr_dat(8'hF0);
    wr_ctl(8'h00);
    wr_ctl(8'h08);
    drain();

    // R10 break, idle and data priority
    expect_char(K_DATA, G_ANY, 8'h81, "R10");
    wr_dat(8'h81);
    expect_char(K_BRK, G_SHORT, 8'h00, "R10");
    expect_char(K_DATA, G_LONG, 8'h3C, "R10");
    wr_dat(8'h3C);
    wr_ctl(8'h00);
    wr_ctl(8'h08);
    wr_ctl(8'h09);
    chk_eq("R5", "tx_done with break queued", tx_done, 1'b0);
    wr_ctl(8'h08);
    drain();

    // R8 disable during traffic drains before release
    expect_char(K_DATA, G_ANY, 8'h99, "R8");
    wr_dat(8'h99);
    expect_char(K_DATA, G_SHORT, 8'h42, "R8");
    wr_dat(8'h42);
    wr_ctl(8'h00);
    repeat (400) @(negedge clk);
    chk_eq("R8", "tx_oe held while draining", tx_oe, 1'b1);
    drain();
    chk_eq("R8", "tx_oe released after drain", tx_oe, 1'b0);
    chk_eq("R5", "tx_done after drain", tx_done, 1'b1);

    // R11 byte held while disabled
    wr_dat(8'h7E);
    repeat (400) @(negedge clk);
    chk_eq("R11", "buf_empty while disabled", buf_empty, 1'b0);
    chk_eq("R11", "tx_oe while disabled", tx_oe, 1'b0);
    chk_eq("R11", "tx_out while disabled", tx_out, 1'b1);
    chk_eq("R11", "tx_done while disabled", tx_done, 1'b0);
    expect_char(K_DATA, G_ANY, 8'h7E, "R11");
    wr_ctl(8'h08);
    drain();
    chk_eq("R11", "buf_empty after enable", buf_empty, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule